// File: doc/BRIEF.md
# Receive Descriptor-Ring DMA Engine

This block takes received Ethernet frames from the MAC as a stream of bytes and moves each one into a main-memory buffer. Frames are first held whole in an on-chip receive FIFO. When a complete frame is waiting, the engine reads the next descriptor of the chosen ring to check that a free buffer is there. It then copies the frame into that buffer byte by byte and writes the descriptor's status word back. Software finds finished frames by polling that status word. The block raises no interrupt.

Two kinds of loss are counted apart. If the FIFO cannot take an incoming byte, that frame is thrown away and the overrun counter goes up. If the next descriptor holds no free buffer, nothing is thrown away: the frame waits in the FIFO, the no-buffer counter goes up, and the descriptor is read again after a short backoff. In multi-ring mode a hash of the frame's address bytes picks one of several rings, and each ring has its own slot index. A jumbo setting raises the buffer limit, and any frame longer than the active limit is cut short and marked as an error.

Top module: `rx_desc_dma`

## Requirements
- R1: After reset both counters read zero, no memory read or write is issued, and every ring's slot index is zero.
- R2: A frame byte that arrives while the FIFO holds FIFO_DEPTH bytes (complete frames plus the frame being received) causes the whole frame to be discarded, including the bytes already stored, and raises the overrun counter by exactly one. Later bytes of that frame are ignored, and the next frame starting after it is stored normally.
- R3: A descriptor is free when bit 31 of its status word (byte offset 4 of the slot) is 1. If it reads 0, the no-buffer counter rises by one for that check, nothing is written to memory, the frame stays in the FIFO, and the descriptor is read again RETRY_GAP cycles later. Once the slot is free, the count stays where it is.
- R4: Byte k of a frame is written to the buffer address held in the slot's word at offset 0, plus k, and frames leave the FIFO in the order they arrived.
- R5: After a frame is copied, the status word is written with bit 31 = 0, bit 30 = truncation error, bits 15:0 = number of bytes written, and every other bit 0.
- R6: When a frame is longer than the active buffer limit, only the first limit bytes are written, the length field equals the limit, and bit 30 is 1. Shorter frames have bit 30 = 0.
- R7: The limit is NORM_BUF bytes while cfgJumbo is 0 and JUMBO_BUF bytes while it is 1.
- R8: Slot s of ring r is an 8-byte descriptor at cfgRingBase + (r*RING_DEPTH + s)*8. A ring's index advances only after a completed frame and goes back to 0 after slot RING_DEPTH-1.
- R9: With cfgMultiRing = 0 every frame uses ring 0. With it set to 1, the first twelve frame bytes (fewer if the frame is shorter) are XORed into one byte h, and the ring number is {h7^h5^h3^h1, h6^h4^h2^h0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Frame byte present this cycle |
| inSof | input | 1 | Byte is the first of a frame |
| inEof | input | 1 | Byte is the last of a frame |
| inData | input | 8 | Frame byte |
| cfgRingBase | input | 32 | Byte address of ring 0 slot 0 |
| cfgMultiRing | input | 1 | Pick the ring by hash |
| cfgJumbo | input | 1 | Use the large buffer limit |
| memRe | output | 1 | Read one 32-bit word; data is returned on memRdata in the following cycle |
| memWe | output | 1 | Write the lanes selected by memBe |
| memAddr | output | 32 | Byte address |
| memBe | output | 4 | Byte-lane enables (lane = address bits 1:0) |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, one cycle after memRe |
| overrunCnt | output | CNT_W | Frames dropped because the FIFO was full |
| noBufCnt | output | CNT_W | Descriptor checks that found no free buffer |

## Verification
The overrun counter changes at the clock edge that takes the overflowing byte. The bench's behavioural occupancy model predicts that edge, and the bench compares the counter on every falling edge while the FIFO is held full by a stalled ring. When a slot is free, the status word of a frame lands 6 + length clocks after its end-of-frame byte. For a stalled frame it lands after the slot is freed plus up to one backoff. For that reason the bench polls each status word with a bounded wait and checks buffer bytes, length and error flag only once ownership has cleared. No-buffer behaviour depends on retry timing, so the bench checks it as a rising count with the descriptor left untouched, and as a count that stays fixed once buffers are supplied.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int OWN_BIT = 31;
  localparam int ERR_BIT = 30;
  localparam int DESC_BYTES = 8;
  localparam int HASH_BYTES = 12;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_STAT, S_CHK_STAT, S_RD_BUF, S_LATCH_BUF, S_COPY, S_WB, S_BACKOFF
  } dmaState_t;

  typedef struct packed {
    logic startFrame;
    logic rdStat;
    logic rdBuf;
    logic latchBuf;
    logic pop;
    logic wrDesc;
    logic bumpIdx;
    logic incNoBuf;
  } ctlStrobes_t;
endpackage

// File: rtl/rxdma_datapath.sv
module rxdma_datapath
  import rxdma_pkg::*;
#(
  parameter int FIFO_DEPTH = 1024,
  parameter int RING_DEPTH = 512,
  parameter int NUM_RINGS  = 4,
  parameter int NORM_BUF   = 1550,
  parameter int JUMBO_BUF  = 16384,
  parameter int CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inEof,
  input  logic [7:0]       inData,
  input  logic [31:0]      cfgRingBase,
  input  logic             cfgMultiRing,
  input  logic             cfgJumbo,
  input  ctlStrobes_t      strb,
  output logic             frameAvail,
  output logic             headLast,
  output logic             ownSeen,
  output logic             memRe,
  output logic             memWe,
  output logic [31:0]      memAddr,
  output logic [3:0]       memBe,
  output logic [31:0]      memWdata,
  input  logic [31:0]      memRdata,
  output logic [CNT_W-1:0] overrunCnt,
  output logic [CNT_W-1:0] noBufCnt
);
  localparam int PTR_W  = $clog2(FIFO_DEPTH);
  localparam int RSEL_W = (NUM_RINGS > 1) ? $clog2(NUM_RINGS) : 1;
  localparam int IDX_W  = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1;
  localparam int OFF_W  = $clog2(JUMBO_BUF + 1);

  function automatic logic [RSEL_W-1:0] foldHash(input logic [7:0] h);
    logic [RSEL_W-1:0] r;
    r = '0;
    for (int i = 0; i < 8; i++) r[i % RSEL_W] = r[i % RSEL_W] ^ h[i];
    return r;
  endfunction

  // Receive FIFO: whole frames only become visible at commitPtr
  logic [8:0]        fifoMem [FIFO_DEPTH];
  logic [RSEL_W-1:0] tagMem  [FIFO_DEPTH];
  logic [PTR_W:0]    wrPtr, startPtr, commitPtr, rdPtr;
  logic [PTR_W:0]    curWr, curStart;
  logic              dropping, live, accept, overflow;
  logic [7:0]        hashAcc, hashNext;
  logic [3:0]        hashCnt;

  assign curWr    = inSof ? commitPtr : wrPtr;
  assign curStart = inSof ? commitPtr : startPtr;
  assign live     = inValid && !(dropping && !inSof);
  assign overflow = live && ((curWr - rdPtr) == (PTR_W+1)'(FIFO_DEPTH));
  assign accept   = live && !overflow;
  assign hashNext = inSof ? inData : ((hashCnt < 4'(HASH_BYTES)) ? (hashAcc ^ inData) : hashAcc);

  always_ff @(posedge clk) begin
    if (accept) begin
      fifoMem[curWr[PTR_W-1:0]] <= {inEof, inData};
      if (inEof) tagMem[curStart[PTR_W-1:0]] <= foldHash(hashNext);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0; startPtr <= '0; commitPtr <= '0; dropping <= 1'b0;
      hashAcc <= '0; hashCnt <= '0; overrunCnt <= '0;
    end else if (accept) begin
      wrPtr    <= curWr + 1'b1;
      startPtr <= curStart;
      dropping <= 1'b0;
      hashAcc  <= hashNext;
      hashCnt  <= inSof ? 4'd1 : ((hashCnt < 4'(HASH_BYTES)) ? hashCnt + 4'd1 : hashCnt);
      if (inEof) commitPtr <= curWr + 1'b1;
    end else if (overflow) begin
      wrPtr      <= curStart;   // roll back the partial frame
      startPtr   <= curStart;
      dropping   <= 1'b1;
      overrunCnt <= overrunCnt + 1'b1;
    end
  end

  logic [8:0] headEntry;
  assign headEntry  = fifoMem[rdPtr[PTR_W-1:0]];
  assign headLast   = headEntry[8];
  assign frameAvail = (rdPtr != commitPtr);
  assign ownSeen    = memRdata[OWN_BIT];

  // Copy state
  logic [RSEL_W-1:0] curRing;
  logic [IDX_W-1:0]  ringIdx [NUM_RINGS];
  logic [31:0]       bufAddr, descAddr, slotNum;
  logic [OFF_W-1:0]  byteOff, limit;
  logic              truncated, wrByte;

  assign limit   = cfgJumbo ? OFF_W'(JUMBO_BUF) : OFF_W'(NORM_BUF);
  assign slotNum = 32'(curRing) * 32'(RING_DEPTH) + 32'(ringIdx[curRing]);
  assign descAddr = cfgRingBase + slotNum * 32'(DESC_BYTES);
  assign wrByte  = strb.pop && (byteOff < limit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0; curRing <= '0; bufAddr <= '0; byteOff <= '0;
      truncated <= 1'b0; noBufCnt <= '0;
      for (int r = 0; r < NUM_RINGS; r++) ringIdx[r] <= '0;
    end else begin
      if (strb.startFrame) begin
        curRing   <= cfgMultiRing ? tagMem[rdPtr[PTR_W-1:0]] : '0;
        byteOff   <= '0;
        truncated <= 1'b0;
      end
      if (strb.latchBuf) bufAddr <= memRdata;
      if (strb.pop) begin
        rdPtr <= rdPtr + 1'b1;
        if (byteOff < limit) byteOff <= byteOff + 1'b1;
        else truncated <= 1'b1;
      end
      if (strb.incNoBuf) noBufCnt <= noBufCnt + 1'b1;
      if (strb.bumpIdx)
        ringIdx[curRing] <= (ringIdx[curRing] == IDX_W'(RING_DEPTH - 1)) ? '0 : ringIdx[curRing] + 1'b1;
    end
  end

  always_comb begin
    memRe    = strb.rdStat || strb.rdBuf;
    memWe    = wrByte || strb.wrDesc;
    memAddr  = bufAddr + 32'(byteOff);
    memBe    = '0;
    memWdata = {4{headEntry[7:0]}};
    if (strb.rdStat || strb.wrDesc) memAddr = descAddr + 32'd4;
    else if (strb.rdBuf)            memAddr = descAddr;
    if (strb.wrDesc) begin
      memBe    = 4'hF;
      memWdata = {1'b0, truncated, 14'b0, 16'(byteOff)};
    end else if (wrByte) begin
      memBe = 4'b0001 << memAddr[1:0];
    end
  end

  a_r1_fifo_bound: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr - rdPtr) <= (PTR_W+1)'(FIFO_DEPTH));
  a_r2_overrun_step: assert property (@(posedge clk) disable iff (!rstN)
    (overrunCnt != $past(overrunCnt)) |-> ($past(inValid) && overrunCnt == $past(overrunCnt) + 1'b1));
  a_r3_nobuf_cause: assert property (@(posedge clk) disable iff (!rstN)
    (noBufCnt != $past(noBufCnt)) |-> !$past(memRdata[OWN_BIT]));
  a_r6_write_in_buffer: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memBe != 4'hF) |-> ((memAddr - bufAddr) < 32'(limit)));

  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_idxChk
    a_r8_idx_range: assert property (@(posedge clk) disable iff (!rstN)
      ringIdx[g] <= IDX_W'(RING_DEPTH - 1));
  end
endmodule

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl
  import rxdma_pkg::*;
#(
  parameter int RETRY_GAP = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameAvail,
  input  logic        headLast,
  input  logic        ownSeen,
  output ctlStrobes_t strb
);
  localparam int GAP_W = $clog2(RETRY_GAP + 1);

  dmaState_t  state, nextState;
  logic [GAP_W-1:0] gapCnt;

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      S_IDLE:      if (frameAvail) begin strb.startFrame = 1'b1; nextState = S_RD_STAT; end
      S_RD_STAT:   begin strb.rdStat = 1'b1; nextState = S_CHK_STAT; end
      S_CHK_STAT:  if (ownSeen) nextState = S_RD_BUF;
                   else begin strb.incNoBuf = 1'b1; nextState = S_BACKOFF; end
      S_RD_BUF:    begin strb.rdBuf = 1'b1; nextState = S_LATCH_BUF; end
      S_LATCH_BUF: begin strb.latchBuf = 1'b1; nextState = S_COPY; end
      S_COPY:      begin strb.pop = 1'b1; if (headLast) nextState = S_WB; end
      S_WB:        begin strb.wrDesc = 1'b1; strb.bumpIdx = 1'b1; nextState = S_IDLE; end
      S_BACKOFF:   if (gapCnt == '0) nextState = S_IDLE;
      default:     nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      gapCnt <= '0;
    end else begin
      state <= nextState;
      if (state == S_CHK_STAT && !ownSeen) gapCnt <= GAP_W'(RETRY_GAP - 1);
      else if (state == S_BACKOFF && gapCnt != '0) gapCnt <= gapCnt - 1'b1;
    end
  end

  a_r4_pop_committed: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> frameAvail);
  a_r3_no_copy_unowned: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RD_BUF) |-> $past(ownSeen));
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
  import rxdma_pkg::*;
#(
  parameter int FIFO_DEPTH = 1024,
  parameter int RING_DEPTH = 512,
  parameter int NUM_RINGS  = 4,
  parameter int NORM_BUF   = 1550,
  parameter int JUMBO_BUF  = 16384,
  parameter int RETRY_GAP  = 16,
  parameter int CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSof,
  input  logic             inEof,
  input  logic [7:0]       inData,
  input  logic [31:0]      cfgRingBase,
  input  logic             cfgMultiRing,
  input  logic             cfgJumbo,
  output logic             memRe,
  output logic             memWe,
  output logic [31:0]      memAddr,
  output logic [3:0]       memBe,
  output logic [31:0]      memWdata,
  input  logic [31:0]      memRdata,
  output logic [CNT_W-1:0] overrunCnt,
  output logic [CNT_W-1:0] noBufCnt
);
  ctlStrobes_t strb;
  logic frameAvail, headLast, ownSeen;

  rxdma_ctrl #(.RETRY_GAP(RETRY_GAP)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameAvail(frameAvail), .headLast(headLast),
    .ownSeen(ownSeen), .strb(strb)
  );

  rxdma_datapath #(
    .FIFO_DEPTH(FIFO_DEPTH), .RING_DEPTH(RING_DEPTH), .NUM_RINGS(NUM_RINGS),
    .NORM_BUF(NORM_BUF), .JUMBO_BUF(JUMBO_BUF), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inData(inData), .cfgRingBase(cfgRingBase), .cfgMultiRing(cfgMultiRing),
    .cfgJumbo(cfgJumbo), .strb(strb), .frameAvail(frameAvail), .headLast(headLast),
    .ownSeen(ownSeen), .memRe(memRe), .memWe(memWe), .memAddr(memAddr),
    .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata),
    .overrunCnt(overrunCnt), .noBufCnt(noBufCnt)
  );
endmodule

// File: tb/tb_rx_desc_dma.sv
module tb_rx_desc_dma;
  localparam int DEPTH = 32;
  localparam int RD    = 4;
  localparam int NB    = 20;
  localparam int JB    = 40;
  localparam logic [31:0] BASE = 32'h100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [7:0] inData = '0;
  logic cfgMultiRing = 1'b0, cfgJumbo = 1'b0;
  logic memRe, memWe;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [3:0] memBe;
  logic [15:0] overrunCnt, noBufCnt;

  always #4 clk = ~clk;

  rx_desc_dma #(.FIFO_DEPTH(DEPTH), .RING_DEPTH(RD), .NUM_RINGS(4), .NORM_BUF(NB),
    .JUMBO_BUF(JB), .RETRY_GAP(4), .CNT_W(16)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inData(inData), .cfgRingBase(BASE), .cfgMultiRing(cfgMultiRing),
    .cfgJumbo(cfgJumbo), .memRe(memRe), .memWe(memWe), .memAddr(memAddr),
    .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata),
    .overrunCnt(overrunCnt), .noBufCnt(noBufCnt)
  );

  // Memory model
  logic [7:0] mem [2048];
  function automatic logic [31:0] rdWord(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction
  function automatic int descA(input int r, input int s);
    return int'(BASE) + (r*RD + s)*8;
  endfunction
  function automatic int bufA(input int r, input int s);
    return 'h400 + (r*RD + s)*64;
  endfunction

  always @(posedge clk) begin
    if (memRe) memRdata <= rdWord(int'(memAddr[10:0]));
    if (memWe)
      for (int i = 0; i < 4; i++)
        if (memBe[i]) mem[{memAddr[10:2], 2'b00} + i] <= memWdata[8*i +: 8];
  end

  int testsRun = 0, testsFailed = 0;
  function automatic void check(input bit ok, input string req, input string what,
                                input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endfunction

  // Overrun occupancy model, valid while the ring is stalled
  bit trackOcc = 0, started = 0;
  int mCommit = 0, mPart = 0, expOverrun = 0;
  bit mDrop = 0;
  always @(posedge clk) begin
    if (trackOcc && inValid && !(mDrop && !inSof)) begin
      if (inSof) begin mPart = 0; mDrop = 0; end
      if (mCommit + mPart == DEPTH) begin expOverrun++; mDrop = 1; mPart = 0; end
      else begin
        mPart++;
        if (inEof) begin mCommit += mPart; mPart = 0; end
      end
    end
  end
  always @(negedge clk)
    if (started) check(overrunCnt == 16'(expOverrun), "R2", "overrun count per clock",
                       overrunCnt, expOverrun);

  logic [7:0] txq[$];
  logic [7:0] f1[$], f2[$], f3[$], f4[$];

  function automatic void buildFrame(input int n, input int seed);
    txq.delete();
    for (int k = 0; k < n; k++) txq.push_back(8'(seed*29 + k*3 + 1));
  endfunction

  function automatic logic [1:0] expRing(input logic [7:0] q[$]);
    logic [7:0] x = '0;
    for (int i = 0; i < q.size() && i < 12; i++) x ^= q[i];
    return {x[7]^x[5]^x[3]^x[1], x[6]^x[4]^x[2]^x[0]};
  endfunction

  task automatic sendFrame();
    for (int k = 0; k < txq.size(); k++) begin
      @(negedge clk);
      inValid = 1'b1; inSof = (k == 0); inEof = (k == txq.size()-1); inData = txq[k];
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
  endtask

  task automatic arm(input int r, input int s);
    @(negedge clk);
    {mem[descA(r,s)+7], mem[descA(r,s)+6], mem[descA(r,s)+5], mem[descA(r,s)+4]} = 32'h8000_0000;
  endtask

  task automatic waitDone(input int r, input int s, input string req);
    int n = 0;
    while (rdWord(descA(r,s)+4) [31] && n < 600) begin @(negedge clk); n++; end
    check(n < 600, req, "completion before timeout", n, 600);
  endtask

  function automatic void checkSlot(input int r, input int s, input logic [7:0] q[$],
                                    input int len, input bit err, input string req);
    logic [31:0] st = rdWord(descA(r,s)+4);
    logic [31:0] expSt = {1'b0, err, 14'b0, 16'(len)};
    bit ok = 1;
    check(st == expSt, req, "status word", st, expSt);
    for (int k = 0; k < len; k++) if (mem[bufA(r,s)+k] != q[k]) ok = 0;
    check(ok, "R4", "buffer bytes", ok, 1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    int nb;
    for (int a = 0; a < 2048; a++) mem[a] = 8'hEE;
    for (int r = 0; r < 4; r++)
      for (int s = 0; s < RD; s++) begin
        {mem[descA(r,s)+3], mem[descA(r,s)+2], mem[descA(r,s)+1], mem[descA(r,s)]} = 32'(bufA(r,s));
        {mem[descA(r,s)+7], mem[descA(r,s)+6], mem[descA(r,s)+5], mem[descA(r,s)+4]} = 32'h0;
      end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    started = 1;
    check(overrunCnt == 0 && noBufCnt == 0, "R1", "counters after reset", {overrunCnt, noBufCnt}, 0);
    check(!memRe && !memWe, "R1", "memory idle after reset", {memRe, memWe}, 0);

    // Single ring, normal frame into slot 0
    for (int s = 0; s < RD; s++) arm(0, s);
    buildFrame(16, 1); f1 = txq; sendFrame();
    waitDone(0, 0, "R5");
    checkSlot(0, 0, f1, 16, 0, "R5");
    check(rdWord(descA(1,0)+4) == 0, "R9", "single mode keeps ring 1 untouched", rdWord(descA(1,0)+4), 0);

    // Truncation
    buildFrame(25, 2); f1 = txq; sendFrame();
    waitDone(0, 1, "R6");
    checkSlot(0, 1, f1, NB, 1, "R6");
    check(mem[bufA(0,1)+NB] == 8'hEE, "R6", "no byte past limit", mem[bufA(0,1)+NB], 8'hEE);

    // Two more, then wrap back to slot 0
    buildFrame(8, 3); f1 = txq; sendFrame();
    buildFrame(9, 4); f2 = txq; sendFrame();
    waitDone(0, 3, "R8");
    checkSlot(0, 2, f1, 8, 0, "R4");
    checkSlot(0, 3, f2, 9, 0, "R8");
    arm(0, 0);
    buildFrame(11, 5); f1 = txq; sendFrame();
    waitDone(0, 0, "R8");
    checkSlot(0, 0, f1, 11, 0, "R8");

    // Stall on slot 1 (not owned) and overflow the FIFO
    repeat (5) @(negedge clk);
    mCommit = 0; mPart = 0; mDrop = 0; trackOcc = 1;
    buildFrame(10, 6); f1 = txq; sendFrame();
    repeat (30) @(negedge clk);
    check(noBufCnt > 0, "R3", "no-buffer count rises", noBufCnt, 1);
    check(rdWord(descA(0,1)+4) == {1'b0, 1'b1, 14'b0, 16'(NB)}, "R3", "stalled descriptor untouched",
          rdWord(descA(0,1)+4), {1'b0, 1'b1, 14'b0, 16'(NB)});
    buildFrame(10, 7); f2 = txq; sendFrame();
    buildFrame(10, 8); f3 = txq; sendFrame();
    buildFrame(10, 9); sendFrame();
    @(negedge clk);
    check(overrunCnt == 1, "R2", "one overrun for dropped frame", overrunCnt, 1);
    trackOcc = 0;
    arm(0, 1); arm(0, 2); arm(0, 3);
    waitDone(0, 3, "R3");
    checkSlot(0, 1, f1, 10, 0, "R3");
    checkSlot(0, 2, f2, 10, 0, "R4");
    checkSlot(0, 3, f3, 10, 0, "R4");
    nb = noBufCnt;
    arm(0, 0);
    buildFrame(12, 10); f4 = txq; sendFrame();
    waitDone(0, 0, "R2");
    checkSlot(0, 0, f4, 12, 0, "R2");
    check(noBufCnt == 16'(nb), "R3", "count holds once buffers exist", noBufCnt, nb);

    // Jumbo limit, then normal limit on the same length
    arm(0, 1);
    cfgJumbo = 1'b1;
    buildFrame(30, 11); f1 = txq; sendFrame();
    waitDone(0, 1, "R7");
    checkSlot(0, 1, f1, 30, 0, "R7");
    cfgJumbo = 1'b0;
    arm(0, 2);
    buildFrame(30, 12); f1 = txq; sendFrame();
    waitDone(0, 2, "R7");
    checkSlot(0, 2, f1, NB, 1, "R7");

    // Multi-ring hashing
    cfgMultiRing = 1'b1;
    arm(1, 0); arm(2, 0); arm(3, 0); arm(0, 3);
    for (int tgt = 0; tgt < 3; tgt++) begin
      int want = (tgt == 0) ? 2 : (tgt == 1) ? 1 : 0;
      int seed = 20;
      buildFrame(14, seed);
      while (expRing(txq) != 2'(want) && seed < 200) begin seed++; buildFrame(14, seed); end
      f1 = txq; sendFrame();
      waitDone(want, (want == 0) ? 3 : 0, "R9");
      checkSlot(want, (want == 0) ? 3 : 0, f1, 14, 0, "R9");
    end

    repeat (10) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule